// File: doc/BRIEF.md
# Receive descriptor ring writer

This block is the receive half of a descriptor-driven network DMA engine, reduced to its bookkeeping. It holds a ring of 32-bit descriptor flag words in an internal memory. The host arms a descriptor by writing its buffer capacity and setting its ownership bit. For each frame arriving on the byte stream, the block claims the descriptor at the current ring slot, provided the host has handed it over. When the last byte arrives it writes back the received length and an overflow indication, clears the ownership bit, pulses a done event and steps to the next slot. After the last slot of the ring it returns to slot 0.

The ring length is selectable at run time from 32, 64, 128 or 256 entries through a configuration word. The same word carries a first-byte offset. The block adds this offset to the byte number of every byte it places, and reports the resulting position together with the slot, so that a payload writer outside the block can store the byte. When a frame finds no armed descriptor, the block drops the whole frame, leaves the ring untouched and raises an error pulse. The host reads any descriptor word through a combinational read port.

Top module: `rxr_ring_writer`

## Requirements
- R1: A synchronous reset sets the ring slot to 0 and drives `rx_done` and `no_desc` low. It sets the configuration to ring-size code 0 with offset 0 and clears every descriptor word to 0.
- R2: Descriptor flag word layout: bits [31:16] hold the capacity while armed and the length once completed, and bit 15 is the ownership bit (1 = hardware may fill). A byte with `in_sof` at a slot whose bit 15 is 1 starts a frame. On its `in_eof` byte the word becomes {length, bit15=0, bit14=overflow, bits[13:0]=0}, where length counts every byte of the frame.
- R3: Bit 14 (overflow) of a completed word is 1 exactly when the length exceeds the armed capacity. Bytes whose 0-based number is at or above the capacity produce no `out_wen`.
- R4: Configuration bits [2:0] hold the ring-size code. The ring has 32 << code entries, and codes 3 to 7 all select 256. The slot wraps from the last entry to 0.
- R5: If bit 15 of the current slot's word is 0 when an `in_sof` byte arrives, `no_desc` is high for the one cycle after that byte. The rest of the frame produces no `out_wen`, writes no descriptor and leaves the slot unchanged.
- R6: `rx_done` is high for the one cycle after the `in_eof` byte of an accepted frame. In that cycle `out_slot` already shows the next slot.
- R7: Configuration bits [5:3] hold the byte offset. For every byte that is placed, `out_pos` equals the offset plus the 0-based byte number, and `out_slot` names the slot being filled.
- R8: An `in_sof` byte that arrives during an unfinished frame abandons that frame without writing its descriptor and starts a new frame in the same slot.
- R9: When a host write and a completion target the same descriptor in the same cycle, the completion is stored and the host write is lost. A host write to any other descriptor in that cycle is stored.
- R10: A reset in the middle of a frame abandons the frame and returns the slot to 0.
- R11: A valid byte without `in_sof` while no frame is open is ignored: it produces no `out_wen`, no event and no descriptor change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | One frame byte is present this cycle |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| host_wr | input | 1 | Host descriptor write strobe |
| host_addr | input | 8 | Descriptor index for host write |
| host_wdata | input | 32 | Descriptor word written by host |
| host_raddr | input | 8 | Descriptor index for host read |
| host_rdata | output | 32 | Descriptor word at host_raddr |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration: [2:0] ring-size code, [5:3] byte offset |
| out_wen | output | 1 | Current byte is to be stored |
| out_slot | output | 8 | Current ring slot |
| out_pos | output | 16 | Byte position inside the slot's buffer |
| rx_done | output | 1 | Descriptor completed last cycle |
| no_desc | output | 1 | Frame dropped for lack of a descriptor |

## Verification
The hardest state to reach from the ports is the wrap at the largest ring. Every one of 256 descriptors must be armed and then consumed in order before the slot returns to 0. The bench reaches it by sweeping each ring-size code, including an out-of-range code that must behave as 256. In each sweep it arms the whole ring and streams one frame per entry, with lengths and capacities chosen arithmetically so that good and overflowing frames alternate irregularly. The exhausted ring left behind by the sweep is then used directly to provoke the no-descriptor drop. A completion is timed against a same-cycle host write to show which write is stored.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int WORD_W  = 32;
   localparam int LEN_W   = 16;
   localparam int LEN_LSB = 16;
   localparam int OWN_BIT = 15;
   localparam int OVF_BIT = 14;

   typedef enum logic [1:0] {
      TRK_IDLE = 2'd0,
      TRK_FILL = 2'd1,
      TRK_DROP = 2'd2
   } trk_state_e;

   function automatic logic [WORD_W-1:0] done_word(input logic [LEN_W-1:0] len,
                                                    input logic ovf);
      logic [WORD_W-1:0] w;
      w = '0;
      w[LEN_LSB +: LEN_W] = len;
      w[OVF_BIT]          = ovf;
      w[OWN_BIT]          = 1'b0;
      return w;
   endfunction
endpackage

// File: rtl/rxr_ring_cfg.sv
module rxr_ring_cfg #(
   parameter int IDX_W    = 8,
   parameter int MIN_LOG2 = 5,
   parameter int CODE_W   = 3,
   parameter int OFF_LSB  = 3,
   parameter int OFF_W    = 3,
   localparam int CFG_W   = OFF_LSB + OFF_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [IDX_W-1:0] ring_mask,
   output logic [OFF_W-1:0] offset
);
   localparam int MAX_CODE = IDX_W - MIN_LOG2;

   logic [CODE_W-1:0] code_q;
   logic [OFF_W-1:0]  off_q;
   logic [CODE_W-1:0] code_eff;

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= '0;
         off_q  <= '0;
      end else if (cfg_wr) begin
         code_q <= cfg_wdata[CODE_W-1:0];
         off_q  <= cfg_wdata[OFF_LSB +: OFF_W];
      end
   end

   always_comb begin
      if (code_q > CODE_W'(MAX_CODE)) code_eff = CODE_W'(MAX_CODE);
      else                            code_eff = code_q;
   end

   for (genvar b = 0; b < IDX_W; b++) begin : g_mask
      assign ring_mask[b] = (b < (MIN_LOG2 + int'(code_eff)));
   end

   assign offset = off_q;

   // R4: the smallest ring is always enabled, so the low mask bits never drop
   p_min_ring_r4: assert property (@(posedge clk) disable iff (rst)
      $countones(ring_mask) >= MIN_LOG2);
endmodule

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
   parameter int IDX_W          = 8,
   parameter int WORD_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int DEPTH         = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hw_we,
   input  logic [IDX_W-1:0]  hw_addr,
   input  logic [WORD_W-1:0] hw_data,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_addr,
   input  logic [WORD_W-1:0] host_data,
   input  logic [IDX_W-1:0]  rd_a_addr,
   output logic [WORD_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_addr,
   output logic [WORD_W-1:0] rd_b_data
);
   logic [WORD_W-1:0] mem_q [DEPTH];
   logic              host_ok;

   assign host_ok = host_we && !(hw_we && (hw_addr == host_addr));

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else begin
            if (host_ok) mem_q[host_addr] <= host_data;
            if (hw_we)   mem_q[hw_addr]   <= hw_data;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (host_ok) mem_q[host_addr] <= host_data;
         if (hw_we)   mem_q[hw_addr]   <= hw_data;
      end
   end

   assign rd_a_data = mem_q[rd_a_addr];
   assign rd_b_data = mem_q[rd_b_addr];

   // R9: a completion always lands, even against a host write to the same entry
   p_hw_lands_r9: assert property (@(posedge clk) disable iff (rst)
      hw_we |=> mem_q[$past(hw_addr)] == $past(hw_data));
   // R9: a host write to an entry not being completed lands
   p_host_lands_r9: assert property (@(posedge clk) disable iff (rst)
      (host_we && !(hw_we && hw_addr == host_addr)) |=>
         mem_q[$past(host_addr)] == $past(host_data));
endmodule

// File: rtl/rxr_frame_track.sv
module rxr_frame_track
   import rxr_pkg::*;
#(
   parameter int OFF_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             byte_vld,
   input  logic             sof,
   input  logic             eof,
   input  logic             own_now,
   input  logic [LEN_W-1:0] cap_now,
   input  logic [OFF_W-1:0] offset,
   output logic             start_drop,
   output logic             complete,
   output logic [LEN_W-1:0] done_len,
   output logic             done_ovf,
   output logic             byte_en,
   output logic [LEN_W-1:0] byte_pos
);
   localparam logic [LEN_W:0] CNT_SAT = {1'b1, {LEN_W{1'b0}}};

   trk_state_e       state_q, state_d;
   logic [LEN_W:0]   cnt_q, n, n1;
   logic [LEN_W-1:0] cap_q, cap_use;
   logic             take_new, drop_new, cont, accept;

   always_comb begin
      take_new = byte_vld && sof && own_now;
      drop_new = byte_vld && sof && !own_now;
      cont     = byte_vld && !sof && (state_q == TRK_FILL);
      accept   = take_new || cont;
      n        = take_new ? '0 : cnt_q;
      cap_use  = take_new ? cap_now : cap_q;
      n1       = (n == CNT_SAT) ? n : n + 1'b1;
      byte_en  = accept && (n < {1'b0, cap_use});
      byte_pos = n[LEN_W-1:0] + {{(LEN_W-OFF_W){1'b0}}, offset};
      complete = accept && eof;
      done_ovf = n1 > {1'b0, cap_use};
      done_len = n1[LEN_W] ? {LEN_W{1'b1}} : n1[LEN_W-1:0];
      start_drop = drop_new;

      state_d = state_q;
      if (accept && eof)                                 state_d = TRK_IDLE;
      else if (take_new)                                 state_d = TRK_FILL;
      else if (drop_new)                                 state_d = eof ? TRK_IDLE : TRK_DROP;
      else if (state_q == TRK_DROP && byte_vld && eof)   state_d = TRK_IDLE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= TRK_IDLE;
         cnt_q   <= '0;
         cap_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept)   cnt_q <= n1;
         if (take_new) cap_q <= cap_now;
      end
   end

   // R6: a completed frame leaves nothing open
   p_close_after_done_r6: assert property (@(posedge clk) disable iff (rst)
      complete |=> state_q == TRK_IDLE);
   // R5: a refused frame places no byte
   p_drop_no_store_r5: assert property (@(posedge clk) disable iff (rst)
      start_drop |-> !byte_en);
   // R11: without an open frame, only a start byte can be placed
   p_idle_ignore_r11: assert property (@(posedge clk) disable iff (rst)
      (state_q != TRK_FILL && byte_en) |-> sof);
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
   import rxr_pkg::*;
#(
   parameter int IDX_W          = 8,
   parameter int MIN_LOG2       = 5,
   parameter int CODE_W         = 3,
   parameter int OFF_LSB        = 3,
   parameter int OFF_W          = 3,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int CFG_W         = OFF_LSB + OFF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic              host_wr,
   input  logic [IDX_W-1:0]  host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   input  logic [IDX_W-1:0]  host_raddr,
   output logic [WORD_W-1:0] host_rdata,
   input  logic              cfg_wr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic              out_wen,
   output logic [IDX_W-1:0]  out_slot,
   output logic [LEN_W-1:0]  out_pos,
   output logic              rx_done,
   output logic              no_desc
);
   initial begin
      if (CODE_W > OFF_LSB)
         $error("ring-size code field overlaps the offset field");
      if (MIN_LOG2 < 1 || MIN_LOG2 > IDX_W)
         $error("smallest ring does not fit the index width");
      if ((1 << CODE_W) - 1 < IDX_W - MIN_LOG2)
         $error("code field too narrow for the ring sizes");
      if (OFF_W >= LEN_W)
         $error("offset wider than the length field");
   end

   logic [IDX_W-1:0]  ring_mask, idx_q, acc_addr;
   logic [OFF_W-1:0]  offset;
   logic [WORD_W-1:0] cur_word, wb_word;
   logic              start_drop, complete, done_ovf, done_q, nodesc_q;
   logic [LEN_W-1:0]  done_len;

   rxr_ring_cfg #(
      .IDX_W(IDX_W), .MIN_LOG2(MIN_LOG2), .CODE_W(CODE_W),
      .OFF_LSB(OFF_LSB), .OFF_W(OFF_W)
   ) u_cfg (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .ring_mask(ring_mask), .offset(offset)
   );

   assign acc_addr = idx_q & ring_mask;

   rxr_frame_track #(.OFF_W(OFF_W)) u_trk (
      .clk(clk), .rst(rst),
      .byte_vld(in_vld), .sof(in_sof), .eof(in_eof),
      .own_now(cur_word[OWN_BIT]),
      .cap_now(cur_word[LEN_LSB +: LEN_W]),
      .offset(offset),
      .start_drop(start_drop), .complete(complete),
      .done_len(done_len), .done_ovf(done_ovf),
      .byte_en(out_wen), .byte_pos(out_pos)
   );

   assign wb_word = done_word(done_len, done_ovf);

   rxr_desc_mem #(
      .IDX_W(IDX_W), .WORD_W(WORD_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_mem (
      .clk(clk), .rst(rst),
      .hw_we(complete), .hw_addr(acc_addr), .hw_data(wb_word),
      .host_we(host_wr), .host_addr(host_addr), .host_data(host_wdata),
      .rd_a_addr(acc_addr), .rd_a_data(cur_word),
      .rd_b_addr(host_raddr), .rd_b_data(host_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q    <= '0;
         done_q   <= 1'b0;
         nodesc_q <= 1'b0;
      end else begin
         done_q   <= complete;
         nodesc_q <= start_drop;
         if (complete) idx_q <= (acc_addr + 1'b1) & ring_mask;
      end
   end

   assign out_slot = acc_addr;
   assign rx_done  = done_q;
   assign no_desc  = nodesc_q;

   // R6: each completion moves the ring one slot forward, wrapping per R4
   p_done_advance_r6: assert property (@(posedge clk) disable iff (rst)
      (rx_done && !$past(cfg_wr)) |-> out_slot == (($past(out_slot) + 1'b1) & ring_mask));
   // R5: a refused frame does not consume a slot
   p_nodesc_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (no_desc && !$past(cfg_wr)) |-> $stable(out_slot));
   // R5: one byte per cycle cannot both finish and refuse a frame
   p_events_excl_r5: assert property (@(posedge clk) disable iff (rst)
      !(rx_done && no_desc));
   // R2: a completed descriptor is handed back to the host
   p_handback_r2: assert property (@(posedge clk) disable iff (rst)
      rx_done |-> !$past(wb_word[OWN_BIT]));
endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_addr = '0, host_raddr = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic        cfg_wr = 1'b0;
   logic [5:0]  cfg_wdata = '0;
   logic        out_wen, rx_done, no_desc;
   logic [7:0]  out_slot;
   logic [15:0] out_pos;

   int n_cmp = 0, n_bad = 0;
   bit reported = 0;

   always #2 clk = ~clk;

   rxr_ring_writer u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_sof(in_sof), .in_eof(in_eof),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_raddr(host_raddr), .host_rdata(host_rdata),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .out_wen(out_wen), .out_slot(out_slot), .out_pos(out_pos),
      .rx_done(rx_done), .no_desc(no_desc)
   );

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int len, input int cap);
      logic [31:0] w;
      w = '0;
      w[31:16] = 16'(len);
      w[14]    = (len > cap);
      return w;
   endfunction

   function automatic logic [31:0] armed(input int cap);
      return {16'(cap), 1'b1, 15'b0};
   endfunction

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(posedge clk); @(posedge clk); #1 rst = 1'b0;
   endtask

   task automatic set_cfg(input int code, input int off);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = {3'(off), 3'(code)};
      @(posedge clk); #1 cfg_wr = 1'b0;
   endtask

   task automatic arm(input int idx, input int cap);
      @(negedge clk); host_wr = 1'b1; host_addr = 8'(idx); host_wdata = armed(cap);
      @(posedge clk); #1 host_wr = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [31:0] w);
      @(negedge clk); host_raddr = 8'(idx); #1 w = host_rdata;
   endtask

   task automatic put_byte(input bit s, input bit e);
      @(negedge clk); in_vld = 1'b1; in_sof = s; in_eof = e;
   endtask

   task automatic end_byte();
      @(posedge clk); #1 in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
   endtask

   // accepted frame: per-byte placement, then completion and write-back
   task automatic frame(input int len, input int slot, input int cap,
                        input int off, input int nxt);
      logic [31:0] w;
      for (int b = 0; b < len; b++) begin
         put_byte(b == 0, b == len - 1);
         #1;
         chk(32'(out_wen), 32'(b < cap), "R3 byte store enable");
         if (b < cap) chk(32'(out_pos), 32'(off + b), "R7 byte position");
         chk(32'(out_slot), 32'(slot), "R7 slot being filled");
         end_byte();
      end
      chk(32'(rx_done), 32'd1, "R6 done pulse");
      chk(32'(out_slot), 32'(nxt), "R6 slot advanced");
      rd(slot, w);
      chk(w, exp_word(len, cap), "R2 completed word");
      @(negedge clk); #1 chk(32'(rx_done), 32'd0, "R6 done lasts one cycle");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      report();
   end

   initial begin
      logic [31:0] w;
      int code, size, off, len, cap;

      do_reset();
      #1;
      chk(32'(out_slot), 0, "R1 slot after reset");
      chk(32'(rx_done), 0, "R1 done low after reset");
      chk(32'(no_desc), 0, "R1 no_desc low after reset");
      rd(0, w);   chk(w, 0, "R1 entry 0 cleared");
      rd(255, w); chk(w, 0, "R1 entry 255 cleared");

      // sweep every ring size, code 7 standing for the clamped 256 case (R4)
      for (int k = 0; k < 5; k++) begin
         code = (k == 4) ? 7 : k;
         size = (code >= 3) ? 256 : (32 << code);
         off  = k + 1;
         set_cfg(code, off);
         for (int i = 0; i < size; i++) arm(i, (i * 3) % 7 + 1);
         for (int i = 0; i < size; i++) begin
            len = (i * 5) % 9 + 1;
            cap = (i * 3) % 7 + 1;
            frame(len, i, cap, off, (i + 1) % size);
         end
         #1 chk(32'(out_slot), 0, "R4 ring wrapped to slot 0");
      end

      // R5: ring exhausted, entry 0 owned by host
      put_byte(1'b1, 1'b0); #1 chk(32'(out_wen), 0, "R5 no store on refused start");
      end_byte();
      chk(32'(no_desc), 1, "R5 no_desc pulse");
      put_byte(1'b0, 1'b0); #1 chk(32'(out_wen), 0, "R5 no store mid refused frame");
      end_byte();
      chk(32'(no_desc), 0, "R5 no_desc lasts one cycle");
      put_byte(1'b0, 1'b1); #1 chk(32'(out_wen), 0, "R5 no store on refused end");
      end_byte();
      chk(32'(rx_done), 0, "R5 no completion for refused frame");
      chk(32'(out_slot), 0, "R5 slot unchanged");
      rd(0, w); chk(w, exp_word(1, 1), "R5 descriptor untouched");

      // R11: stray bytes with no open frame
      arm(0, 10);
      put_byte(1'b0, 1'b0); #1 chk(32'(out_wen), 0, "R11 stray byte ignored");
      end_byte();
      put_byte(1'b0, 1'b1); #1 chk(32'(out_wen), 0, "R11 stray end ignored");
      end_byte();
      chk(32'(rx_done), 0, "R11 no done");
      chk(32'(no_desc), 0, "R11 no error");
      rd(0, w); chk(w, armed(10), "R11 descriptor still armed");

      // R8: restart with a new start byte inside an open frame
      put_byte(1'b1, 1'b0); #1 chk(32'(out_wen), 1, "R8 partial frame placed");
      end_byte();
      put_byte(1'b0, 1'b0); end_byte();
      chk(32'(rx_done), 0, "R8 partial frame not completed");
      frame(2, 0, 10, 5, 1);

      // R9: completion and host write to the same entry
      arm(1, 4); arm(2, 4);
      @(negedge clk);
      in_vld = 1'b1; in_sof = 1'b1; in_eof = 1'b1;
      host_wr = 1'b1; host_addr = 8'd1; host_wdata = 32'hABCD_8000;
      @(posedge clk); #1;
      in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0; host_wr = 1'b0;
      chk(32'(rx_done), 1, "R9 completion under collision");
      rd(1, w); chk(w, exp_word(1, 4), "R9 completion wins the entry");

      // R9: completion and host write to a different entry
      @(negedge clk);
      in_vld = 1'b1; in_sof = 1'b1; in_eof = 1'b1;
      host_wr = 1'b1; host_addr = 8'd3; host_wdata = armed(6);
      @(posedge clk); #1;
      in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0; host_wr = 1'b0;
      rd(2, w); chk(w, exp_word(1, 4), "R9 completion stored");
      rd(3, w); chk(w, armed(6), "R9 host write elsewhere stored");
      frame(3, 3, 6, 5, 4);

      // R10: reset in the middle of a frame
      arm(4, 5);
      put_byte(1'b1, 1'b0); end_byte();
      put_byte(1'b0, 1'b0); end_byte();
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      chk(32'(out_slot), 0, "R10 slot back to 0");
      chk(32'(rx_done), 0, "R10 no done after reset");
      chk(32'(no_desc), 0, "R10 no error after reset");
      rd(4, w); chk(w, 0, "R10 entry cleared by reset");

      // after reset: ring of 32 with offset 0 (R1)
      for (int i = 0; i < 32; i++) arm(i, 2);
      for (int i = 0; i < 32; i++) frame(1 + (i % 4), i, 2, 0, (i + 1) % 32);
      #1 chk(32'(out_slot), 0, "R1 default ring is 32 entries");

      report();
   end
endmodule